// File: doc/BRIEF.md
# Three-Channel Quadrature Step Counter with Interrupt

This block serves three rotary knobs, each a mechanical quadrature encoder with two contacts, A and B. Every contact signal is brought into the clock domain by a two-stage synchroniser. It then passes a chatter filter, which accepts a new level only after the level has held for `FILT_CYC` clock cycles. The parameter is sized by the integrator to roughly 620 ns at the chosen clock.

A small state machine per channel follows the filtered A/B pair and marks one step for each full detent. The step is an up step when A leads B, which is clockwise, and a down step when B leads A, which is counter-clockwise. Each channel keeps a 3-bit count that saturates at both ends, together with a direction flag. Any step on any channel raises a shared interrupt, and the interrupt stays high until the host reads the switch data.

The host reads by selecting the switch-readout mode and then lowering chip-select. On that falling edge the block copies all channels into a 12-bit snapshot register, clears the counts and drops the interrupt. The snapshot holds the bits in the order in which a serial shifter emits them.

The step decoder states are named after the filtered A/B levels: `PH_00` (rest), `PH_10` (A high only), `PH_11` (both high) and `PH_01` (B high only). The state always follows the inputs.
- The transition `PH_10 -> PH_11` issues an up step.
- The transition `PH_01 -> PH_11` issues a down step.
- Every other transition issues nothing. This covers `PH_00 -> PH_10`, `PH_00 -> PH_01`, `PH_11 -> PH_01`, `PH_11 -> PH_10`, `PH_10 -> PH_00`, `PH_01 -> PH_00`, and any jump in which both inputs change at once.

Top module: `quad_enc_irq`

## Requirements
- R1: After reset `irq` is 0 and `snap` is all zeros. All counts and direction flags are 0, and every decoder is in `PH_00`.
- R2: A level change on `enc_a[i]` or `enc_b[i]` that lasts fewer than `FILT_CYC` cycles is ignored. A level change that is held is acted on at the rising clock edge `FILT_CYC+3` edges after the input changed, and not one edge earlier.
- R3: Each channel gives one up step when its filtered inputs go from A=1,B=0 to A=1,B=1 (clockwise). It gives one down step when they go from A=0,B=1 to A=1,B=1 (counter-clockwise). No other transition gives a step, and up and down steps never occur together.
- R4: An up step increments the 3-bit count. At 7 the count stays at 7.
- R5: A down step decrements the count. At 0 the count stays at 0.
- R6: A down step sets the direction flag to 1 (counter-clockwise). An up step always leaves the count positive and therefore clears the flag to 0 (clockwise). A readout leaves the flag unchanged.
- R7: A step on any channel sets `irq` at the same edge that updates the count. `irq` then stays high until a readout.
- R8: A readout happens at the edge where `cs` is seen falling, meaning it was 1 at the previous edge and is 0 now, while `rd_mode` is 1. A readout loads `snap`, clears every count to 0 and clears `irq`. A falling `cs` while `rd_mode` is 0 changes nothing.
- R9: `snap` holds channel i in bits `4i` to `4i+3`. Bit `4i` is the direction flag and bits `4i+1` to `4i+3` are count bits LSB to MSB. Bit 0 is the first bit shifted out. The snapshot holds the values from just before the readout edge.
- R10: A step that arrives at the same edge as a readout is not lost. Its channel restarts from 0 with that step applied, and `irq` stays 1.
- R11: The channels are independent. A channel's count changes only on its own steps or on a readout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | CHANNELS | Encoder contact A per channel, asynchronous |
| enc_b | input | CHANNELS | Encoder contact B per channel, asynchronous |
| cs | input | 1 | Chip-select, synchronous to `clk` |
| rd_mode | input | 1 | Switch-readout mode is selected |
| irq | output | 1 | Interrupt: a step occurred since the last readout |
| snap | output | CHANNELS*(CNT_W+1) | Snapshot captured at readout |

## Verification
An input edge reaches the counts and `irq` at the `FILT_CYC+3`-th rising edge after it is driven. That delay is two synchroniser stages, `FILT_CYC` filter cycles and the counter register. The bench drives inputs on falling edges and samples at the falling edge after the edge at which a result is due. The latency test looks at `irq` one edge early and again exactly on time. A readout takes effect at the edge where `cs` is seen low, so `snap` and the cleared `irq` are checked at the next falling edge. For the coincident step-and-readout case, the `cs` fall is placed so that the readout edge is the very edge at which the step lands.

// File: rtl/enc_pkg.sv
package enc_pkg;

    // Decoder states, named by the filtered A then B level.
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_10 = 2'b10,
        PH_11 = 2'b11,
        PH_01 = 2'b01
    } ph_state_t;

    function automatic ph_state_t ph_of(input logic a, input logic b);
        ph_state_t s;
        unique case ({a, b})
            2'b00:   s = PH_00;
            2'b10:   s = PH_10;
            2'b11:   s = PH_11;
            default: s = PH_01;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/enc_filter.sv
module enc_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic          sync1, sync2;
    logic [CW-1:0] run;

    // Two-stage synchroniser.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // Accept a new level after FILT_CYC consecutive cycles of disagreement.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean <= 1'b0;
            run   <= '0;
        end else if (sync2 == clean) begin
            run <= '0;
        end else if (run == LAST) begin
            clean <= sync2;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/enc_phase.sv
module enc_phase
    import enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic up,
    output logic dn
);
    ph_state_t state, nxt;

    assign nxt = ph_of(a, b);

    // State register: the state always follows the filtered inputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_00;
        else        state <= nxt;
    end

    // Outputs: a step is issued only on entry to PH_11.
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state)
            PH_10:   up = (nxt == PH_11);
            PH_01:   dn = (nxt == PH_11);
            PH_00,
            PH_11:   ;
            default: ;
        endcase
    end

endmodule

// File: rtl/enc_chan.sv
module enc_chan #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             dn,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             dir
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= 1'b0;
        end else if (clr) begin
            // Restart from zero, keeping a step that lands on the same edge.
            cnt <= up ? ONE : '0;
            if (up)      dir <= 1'b0;
            else if (dn) dir <= 1'b1;
        end else if (up) begin
            cnt <= (cnt == TOP) ? TOP : cnt + 1'b1;
            dir <= 1'b0;
        end else if (dn) begin
            cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
            dir <= 1'b1;
        end
    end

endmodule

// File: rtl/quad_enc_irq.sv
module quad_enc_irq #(
    parameter int CHANNELS = 3,
    parameter int CNT_W    = 3,
    parameter int FILT_CYC = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CHANNELS-1:0]             enc_a,
    input  logic [CHANNELS-1:0]             enc_b,
    input  logic                            cs,
    input  logic                            rd_mode,
    output logic                            irq,
    output logic [CHANNELS*(CNT_W+1)-1:0]   snap
);
    localparam int FLD_W  = CNT_W + 1;
    localparam int SNAP_W = CHANNELS * FLD_W;

    logic [CHANNELS-1:0]       a_cl, b_cl, up_w, dn_w, dir_w;
    logic [CHANNELS*CNT_W-1:0] cnt_w;
    logic [SNAP_W-1:0]         fields;
    logic                      cs_q, strobe, any_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs;
    end

    assign strobe   = cs_q & ~cs & rd_mode;
    assign any_step = |(up_w | dn_w);

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        enc_filter #(.FILT_CYC(FILT_CYC)) u_fa (
            .clk(clk), .rst_n(rst_n), .raw(enc_a[i]), .clean(a_cl[i]));
        enc_filter #(.FILT_CYC(FILT_CYC)) u_fb (
            .clk(clk), .rst_n(rst_n), .raw(enc_b[i]), .clean(b_cl[i]));
        enc_phase u_ph (
            .clk(clk), .rst_n(rst_n), .a(a_cl[i]), .b(b_cl[i]),
            .up(up_w[i]), .dn(dn_w[i]));
        enc_chan #(.CNT_W(CNT_W)) u_cn (
            .clk(clk), .rst_n(rst_n), .up(up_w[i]), .dn(dn_w[i]), .clr(strobe),
            .cnt(cnt_w[i*CNT_W +: CNT_W]), .dir(dir_w[i]));
        // Shift order per channel: direction first, then count LSB to MSB.
        assign fields[i*FLD_W +: FLD_W] = {cnt_w[i*CNT_W +: CNT_W], dir_w[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            snap <= '0;
        end else begin
            if (any_step)    irq <= 1'b1;
            else if (strobe) irq <= 1'b0;
            if (strobe)      snap <= fields;
        end
    end

endmodule

// File: rtl/enc_chk.sv
module enc_chk #(
    parameter int CHANNELS = 3,
    parameter int CNT_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CHANNELS-1:0]           up,
    input  logic [CHANNELS-1:0]           dn,
    input  logic                          strobe,
    input  logic [CHANNELS*CNT_W-1:0]     cnt,
    input  logic [CHANNELS-1:0]           dir,
    input  logic                          irq,
    input  logic [CHANNELS*(CNT_W+1)-1:0] snap
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam int FLD_W = CNT_W + 1;

    logic [CHANNELS*FLD_W-1:0] packed_now;
    for (genvar j = 0; j < CHANNELS; j++) begin : g_pk
        for (genvar k = 0; k < CNT_W; k++) begin : g_bit
            assign packed_now[j*FLD_W + 1 + k] = cnt[j*CNT_W + k];
        end
        assign packed_now[j*FLD_W] = dir[j];
    end

    for (genvar i = 0; i < CHANNELS; i++) begin : g_a
        p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(up[i] && dn[i]));
        p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (up[i] && !strobe && cnt[i*CNT_W +: CNT_W] == TOP)
                |=> cnt[i*CNT_W +: CNT_W] == TOP);
        p_sat_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (dn[i] && !strobe && cnt[i*CNT_W +: CNT_W] == '0)
                |=> cnt[i*CNT_W +: CNT_W] == '0);
        p_dir_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            dn[i] |=> dir[i]);
        p_dir_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            up[i] |=> !dir[i]);
        p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!up[i] && !dn[i] && !strobe) |=> $stable(cnt[i*CNT_W +: CNT_W]));
    end

    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(up | dn)));
    p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !(|(up | dn))) |=> !irq);
    p_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> snap == $past(packed_now));
    p_coinc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && |(up | dn)) |=> irq);

endmodule

bind quad_enc_irq enc_chk #(.CHANNELS(CHANNELS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up(up_w), .dn(dn_w), .strobe(strobe),
    .cnt(cnt_w), .dir(dir_w), .irq(irq), .snap(snap));

// File: tb/sim_quad_enc_irq.sv
module sim_quad_enc_irq;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 8;
    localparam int SETTLE = FILT + 4;

    typedef struct packed {
        logic [1:0] ch;
        logic [3:0] nup;
        logic [3:0] ndn;
        logic [2:0] ecnt;
        logic       edir;
    } vec_t;

    // Each vector: up steps, then down steps on one channel, then a readout.
    localparam vec_t VEC [0:7] = '{
        '{2'd0, 4'd2, 4'd0, 3'd2, 1'b0},
        '{2'd1, 4'd0, 4'd1, 3'd0, 1'b1},   // R5 down at zero
        '{2'd2, 4'd9, 4'd0, 3'd7, 1'b0},   // R4 saturate at top
        '{2'd0, 4'd3, 4'd1, 3'd2, 1'b1},
        '{2'd1, 4'd1, 4'd3, 3'd0, 1'b1},
        '{2'd2, 4'd0, 4'd2, 3'd0, 1'b1},
        '{2'd0, 4'd7, 4'd0, 3'd7, 1'b0},
        '{2'd1, 4'd4, 4'd2, 3'd2, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] enc_a = '0, enc_b = '0;
    logic cs = 1'b0, rd_mode = 1'b0;
    logic irq;
    logic [11:0] snap;

    int n_chk = 0, n_bad = 0;
    logic [2:0] m_cnt [3];
    logic       m_dir [3];

    quad_enc_irq #(.CHANNELS(3), .CNT_W(3), .FILT_CYC(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .cs(cs), .rd_mode(rd_mode), .irq(irq), .snap(snap));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model_snap();
        logic [11:0] s;
        for (int c = 0; c < 3; c++) s[c*4 +: 4] = {m_cnt[c], m_dir[c]};
        return s;
    endfunction

    task automatic set_a(input int ch, input logic v);
        @(negedge clk) enc_a[ch] = v;
        repeat (SETTLE) @(posedge clk);
    endtask

    task automatic set_b(input int ch, input logic v);
        @(negedge clk) enc_b[ch] = v;
        repeat (SETTLE) @(posedge clk);
    endtask

    task automatic do_step(input int ch, input bit cw);
        if (cw) begin
            set_a(ch, 1); set_b(ch, 1); set_a(ch, 0); set_b(ch, 0);
            m_cnt[ch] = (m_cnt[ch] == 3'd7) ? 3'd7 : m_cnt[ch] + 3'd1;
            m_dir[ch] = 1'b0;
        end else begin
            set_b(ch, 1); set_a(ch, 1); set_b(ch, 0); set_a(ch, 0);
            m_cnt[ch] = (m_cnt[ch] == 3'd0) ? 3'd0 : m_cnt[ch] - 3'd1;
            m_dir[ch] = 1'b1;
        end
    endtask

    // Readout: cs high then low while rd_mode is 1; check at the next falling edge.
    task automatic readout(input string req);
        @(negedge clk) begin rd_mode = 1'b1; cs = 1'b1; end
        @(negedge clk) cs = 1'b0;
        @(negedge clk);
        check({req, " snap"}, 32'(snap), 32'(model_snap()));
        check("R8 irq cleared", 32'(irq), 32'd0);
        for (int c = 0; c < 3; c++) m_cnt[c] = 3'd0;
        rd_mode = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin m_cnt[c] = 3'd0; m_dir[c] = 1'b0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 snap", 32'(snap), 32'd0);
        rst_n = 1'b1;

        // Table walk: R3 R4 R5 R6 R7 R9 R11
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < int'(VEC[v].nup); k++) do_step(int'(VEC[v].ch), 1'b1);
            for (int k = 0; k < int'(VEC[v].ndn); k++) do_step(int'(VEC[v].ch), 1'b0);
            repeat (20) @(negedge clk);
            check("R7 irq held", 32'(irq), 32'd1);
            readout("R9 R11");
            check("R3 R6 field", 32'(snap[VEC[v].ch*4 +: 4]),
                  32'({VEC[v].ecnt, VEC[v].edir}));
        end

        // R8: cs falling with rd_mode low changes nothing
        do_step(2, 1'b1);
        @(negedge clk) cs = 1'b1;
        @(negedge clk) cs = 1'b0;
        @(negedge clk);
        check("R8 ignored irq", 32'(irq), 32'd1);
        check("R8 ignored snap", 32'(snap[11:8]), 32'({3'd0, 1'b1}));
        readout("R8");
        check("R8 count kept", 32'(snap[11:8]), 32'({3'd1, 1'b0}));

        // R2: glitch on B shorter than the filter is ignored
        set_a(1, 1);
        @(negedge clk) enc_b[1] = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        enc_b[1] = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R2 glitch irq", 32'(irq), 32'd0);
        set_a(1, 0);
        readout("R2 glitch");

        // R2: latency of a held edge is FILT+3 edges
        set_a(0, 1);
        @(negedge clk) enc_b[0] = 1'b1;
        repeat (FILT + 2) @(posedge clk);
        @(negedge clk);
        check("R2 early", 32'(irq), 32'd0);
        @(negedge clk);
        check("R2 on time", 32'(irq), 32'd1);
        set_a(0, 0); set_b(0, 0);
        m_cnt[0] = 3'd1; m_dir[0] = 1'b0;
        readout("R2 latency");

        // R10: step lands on the readout edge
        do_step(0, 1'b1); do_step(0, 1'b1); do_step(0, 1'b1);
        set_a(0, 1);
        @(negedge clk) begin rd_mode = 1'b1; cs = 1'b1; end
        @(negedge clk) enc_b[0] = 1'b1;
        repeat (FILT + 2) @(posedge clk);
        @(negedge clk) cs = 1'b0;
        @(negedge clk);
        check("R10 snap", 32'(snap[3:0]), 32'({3'd3, 1'b0}));
        check("R10 irq kept", 32'(irq), 32'd1);
        rd_mode = 1'b0;
        set_a(0, 0); set_b(0, 0);
        m_cnt[0] = 3'd1; m_dir[0] = 1'b0;
        readout("R10 restart");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule